// File: doc/BRIEF.md
# TDM Receive Slot Mask Unit

This block sits in the receive path of a time-division-multiplexed serial audio port. It counts the slots in each frame and, at the end of each slot, uses one enable bit per slot to decide whether the word now held in the receive shift register is moved into the receive holding register. An enabled slot moves the word across and raises the receive-full flag, which also serves as the receive interrupt. A disabled slot lets shifting carry on, but the word is dropped and no flag changes. The serial shifter and the bit clock are outside this block. It sees only a frame-sync pulse, a slot-end strobe and the parallel word.

The 32-slot enable mask is written by the host as two 16-bit halves. Each write goes into a written copy that reads back at once. The copy that gates transfers is loaded from the written copy only on a frame-sync pulse, so a mask change never splits a frame. In normal (single-slot) operation only slot 0 is used, so bit 0 of the low half must stay set or nothing is received.

The holding register is presented to the host as a valid/ready stream (`rxd_valid`, `rxd_ready`, `rxd_data`). The serial side cannot be stalled, so back-pressure is never passed upstream. If the host has not taken a word when the next enabled slot ends, the new word replaces the old one, `rxd_valid` stays high and the sticky `overrun` flag is raised. This means `rxd_data` may change while `rxd_valid` is high, but only in an overrun.

Top module: `rx_slot_mask`

## Requirements
- R1: After reset, `rxd_valid` and `overrun` are 0, `slot_idx` is 0, both mask read-back ports show 0xFFFF, and every slot of the first frame is enabled.
- R2: `mask_wr_lo` stores `mask_wdata` as the enables for slots 0–15 (bit n is slot n). `mask_wr_hi` stores it as the enables for slots 16–31 (bit n is slot 16+n). `mask_lo_rd` and `mask_hi_rd` show the last written value from the cycle after the write, whatever mask is active.
- R3: The active mask changes only on a cycle with `frame_sync` high, when it takes the written mask. A write made during a frame does not change which slots of that frame are transferred.
- R4: `frame_sync` sets `slot_idx` to 0 on the next cycle. Otherwise each `slot_end` adds one, saturating at 31. A `slot_end` in the same cycle as `frame_sync` is judged with the old slot index and the old active mask.
- R5: A `slot_end` in an enabled slot drives `xfer_o` high in that same cycle. `rxd_data` then holds `rx_word` and `rxd_valid` is 1 from the next cycle.
- R6: A `slot_end` in a disabled slot keeps `xfer_o` low and leaves `rxd_data`, `rxd_valid` and `overrun` unchanged.
- R7: A cycle with `rxd_valid` and `rxd_ready` both high consumes the word: `rxd_valid` is 0 on the next cycle unless a transfer happens in the same cycle.
- R8: A transfer while `rxd_valid` is 1 and `rxd_ready` is 0 overwrites `rxd_data` and sets `overrun`. `overrun` stays set until a cycle with `overrun_clr` high, and a new overrun in that cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| frame_sync | input | 1 | One-cycle pulse at the start of a frame |
| slot_end | input | 1 | One-cycle strobe at the end of each slot |
| rx_word | input | 24 | Word currently held in the receive shift register |
| mask_wr_lo | input | 1 | Write `mask_wdata` to the slot 0–15 enables |
| mask_wr_hi | input | 1 | Write `mask_wdata` to the slot 16–31 enables |
| mask_wdata | input | 16 | Mask write data |
| mask_lo_rd | output | 16 | Last written value of the low half |
| mask_hi_rd | output | 16 | Last written value of the high half |
| slot_idx | output | 5 | Index of the slot being received |
| xfer_o | output | 1 | Transfer strobe for the current slot end |
| rxd_data | output | 24 | Receive holding register |
| rxd_valid | output | 1 | Receive-full flag and interrupt |
| rxd_ready | input | 1 | Host takes the held word |
| overrun | output | 1 | Sticky overrun flag |
| overrun_clr | input | 1 | Clears `overrun` |

## Verification
Faults in the slot counter or the active mask show up at the first `slot_end` that follows. `xfer_o` is wrong in that same cycle, and the scoreboard then sees a word that is missing, extra or out of order. A written mask that reaches the active copy outside `frame_sync` changes transfers inside a frame, and the frames in which the mask is changed mid-frame expose it. Holding-register flag errors appear one cycle after the triggering strobe, either as an `overrun` that is wrong or as a word that the host never receives.

// File: rtl/rx_slot_mask_pkg.sv
package rx_slot_mask_pkg;
  localparam int unsigned DEF_WORD_W  = 24;
  localparam int unsigned DEF_HALF_W  = 16;
  localparam int unsigned MASK_HALVES = 2;
  localparam int unsigned HALF_LO     = 0;
  localparam int unsigned HALF_HI     = 1;
endpackage

// File: rtl/rsm_mask_bank.sv
module rsm_mask_bank #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned HALVES = 2,
  localparam int unsigned MASK_W = HALF_W * HALVES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALVES-1:0] wr_en,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              frame_sync,
  output logic [MASK_W-1:0] written,
  output logic [MASK_W-1:0] active
);
  logic [HALF_W-1:0] half_q [HALVES];

  // One written register per half; bit n of half h enables slot h*HALF_W+n.
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         half_q[h] <= '1;
      else if (wr_en[h])  half_q[h] <= wr_data;
    end
    assign written[h*HALF_W +: HALF_W] = half_q[h];
  end

  // The active copy is loaded only at the frame boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          active <= '1;
    else if (frame_sync) active <= written;
  end

  // R3: active mask holds between frame syncs
  a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(active));
  // R3: frame sync takes the written copy
  a_r3_active_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> active == $past(written));
endmodule

// File: rtl/rsm_slot_counter.sv
module rsm_slot_counter #(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              slot_end,
  output logic [SLOT_W-1:0] slot_idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           slot_idx <= '0;
    else if (frame_sync)                  slot_idx <= '0;
    else if (slot_end && slot_idx != LAST) slot_idx <= slot_idx + 1'b1;
  end

  // R4: frame sync restarts the count
  a_r4_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> slot_idx == '0);
  // R4: count saturates on the last slot
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && slot_end && slot_idx == LAST) |=> slot_idx == LAST);
  // R4: no movement without a strobe
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && !slot_end) |=> $stable(slot_idx));
endmodule

// File: rtl/rsm_rx_holding.sv
module rsm_rx_holding #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [WORD_W-1:0] word_in,
  input  logic              rd_ready,
  input  logic              ovr_clr,
  output logic [WORD_W-1:0] data_q,
  output logic              valid_q,
  output logic              ovr_q
);
  logic taken;
  assign taken = valid_q && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (xfer) begin
        data_q  <= word_in;
        valid_q <= 1'b1;
      end else if (taken) begin
        valid_q <= 1'b0;
      end
      if (xfer && valid_q && !rd_ready) ovr_q <= 1'b1;
      else if (ovr_clr)                 ovr_q <= 1'b0;
    end
  end

  // R8: unread word overwritten raises overrun
  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && valid_q && !rd_ready) |=> ovr_q);
  // R7: consumed word drops the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !xfer) |=> !valid_q);
  // R5: transfer always leaves the flag set
  a_r5_xfer_sets: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> valid_q);
endmodule

// File: rtl/rx_slot_mask.sv
module rx_slot_mask
  import rx_slot_mask_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned HALF_W = DEF_HALF_W,
  localparam int unsigned NUM_SLOTS = HALF_W * MASK_HALVES,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              slot_end,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              mask_wr_lo,
  input  logic              mask_wr_hi,
  input  logic [HALF_W-1:0] mask_wdata,
  output logic [HALF_W-1:0] mask_lo_rd,
  output logic [HALF_W-1:0] mask_hi_rd,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              xfer_o,
  output logic [WORD_W-1:0] rxd_data,
  output logic              rxd_valid,
  input  logic              rxd_ready,
  output logic              overrun,
  input  logic              overrun_clr
);
  logic [MASK_HALVES-1:0] wr_en;
  logic [NUM_SLOTS-1:0]   mask_written;
  logic [NUM_SLOTS-1:0]   mask_active;
  logic                   slot_enabled;

  always_comb begin
    wr_en          = '0;
    wr_en[HALF_LO] = mask_wr_lo;
    wr_en[HALF_HI] = mask_wr_hi;
  end

  rsm_mask_bank #(.HALF_W(HALF_W), .HALVES(MASK_HALVES)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(mask_wdata),
    .frame_sync(frame_sync), .written(mask_written), .active(mask_active)
  );

  rsm_slot_counter #(.NUM_SLOTS(NUM_SLOTS)) u_count (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .slot_end(slot_end), .slot_idx(slot_idx)
  );

  assign mask_lo_rd   = mask_written[HALF_LO*HALF_W +: HALF_W];
  assign mask_hi_rd   = mask_written[HALF_HI*HALF_W +: HALF_W];
  assign slot_enabled = mask_active[slot_idx];
  assign xfer_o       = slot_end && slot_enabled;

  rsm_rx_holding #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .xfer(xfer_o), .word_in(rx_word),
    .rd_ready(rxd_ready), .ovr_clr(overrun_clr),
    .data_q(rxd_data), .valid_q(rxd_valid), .ovr_q(overrun)
  );

  // R6: a disabled slot leaves every holding flag and the data alone
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !mask_active[slot_idx] && !rxd_ready && !overrun_clr)
      |=> ($stable(rxd_valid) && $stable(rxd_data) && $stable(overrun)));
  // R2: written halves update on their own strobe only
  a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_lo |=> $stable(mask_lo_rd));
  a_r2_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_hi |=> $stable(mask_hi_rd));
endmodule

// File: tb/rx_slot_mask_tb.sv
module rx_slot_mask_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0;
  logic        slot_end = 1'b0;
  logic [23:0] rx_word = '0;
  logic        mask_wr_lo = 1'b0;
  logic        mask_wr_hi = 1'b0;
  logic [15:0] mask_wdata = '0;
  logic [15:0] mask_lo_rd, mask_hi_rd;
  logic [4:0]  slot_idx;
  logic        xfer_o;
  logic [23:0] rxd_data;
  logic        rxd_valid;
  logic        rxd_ready = 1'b0;
  logic        overrun;
  logic        overrun_clr = 1'b0;

  int checks = 0;
  int failures = 0;
  bit mon_en = 1'b1;
  bit done = 1'b0;
  logic [31:0] pend_m = '1;
  logic [31:0] act_m = '1;
  logic [23:0] sbq [$];

  always #5 clk = ~clk;

  rx_slot_mask u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_end(slot_end),
    .rx_word(rx_word), .mask_wr_lo(mask_wr_lo), .mask_wr_hi(mask_wr_hi),
    .mask_wdata(mask_wdata), .mask_lo_rd(mask_lo_rd), .mask_hi_rd(mask_hi_rd),
    .slot_idx(slot_idx), .xfer_o(xfer_o), .rxd_data(rxd_data),
    .rxd_valid(rxd_valid), .rxd_ready(rxd_ready), .overrun(overrun),
    .overrun_clr(overrun_clr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard whenever a word is presented.
  always @(negedge clk) begin
    if (rxd_ready) rxd_ready = 1'b0;
    else if (mon_en && rxd_valid) begin
      if (sbq.size() == 0) chk(1'b0, "R5 unexpected word", {8'h0, rxd_data}, 32'h0);
      else begin
        logic [23:0] e;
        e = sbq.pop_front();
        chk(rxd_data == e, "R5 word", {8'h0, rxd_data}, {8'h0, e});
      end
      rxd_ready = 1'b1;
    end
  end

  task automatic write_mask(input bit hi, input logic [15:0] v);
    @(negedge clk);
    mask_wr_lo = !hi; mask_wr_hi = hi; mask_wdata = v;
    if (hi) pend_m[31:16] = v; else pend_m[15:0] = v;
    @(negedge clk);
    mask_wr_lo = 1'b0; mask_wr_hi = 1'b0;
    if (hi) chk(mask_hi_rd == v, "R2 hi readback", {16'h0, mask_hi_rd}, {16'h0, v});
    else    chk(mask_lo_rd == v, "R2 lo readback", {16'h0, mask_lo_rd}, {16'h0, v});
  endtask

  task automatic frame();
    @(negedge clk);
    frame_sync = 1'b1;
    act_m = pend_m;
    @(negedge clk);
    frame_sync = 1'b0;
    chk(slot_idx == 5'd0, "R4 sync zero", {27'h0, slot_idx}, 32'h0);
  endtask

  // Drives one slot end; n is the slot number within the frame.
  task automatic do_slot(input int n, input logic [23:0] w, input bit push);
    bit en;
    en = act_m[(n > 31) ? 31 : n];
    @(negedge clk);
    slot_end = 1'b1; rx_word = w;
    if (en && push) sbq.push_back(w);
    #1;
    if (en) chk(xfer_o == 1'b1, "R5 strobe", {31'h0, xfer_o}, 32'h1);
    else    chk(xfer_o == 1'b0, "R6 strobe", {31'h0, xfer_o}, 32'h0);
    @(negedge clk);
    slot_end = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rxd_valid == 1'b0, "R1 valid", {31'h0, rxd_valid}, 32'h0);
    chk(overrun == 1'b0, "R1 overrun", {31'h0, overrun}, 32'h0);
    chk(slot_idx == 5'd0, "R1 slot", {27'h0, slot_idx}, 32'h0);
    chk(mask_lo_rd == 16'hFFFF, "R1 lo", {16'h0, mask_lo_rd}, 32'hFFFF);
    chk(mask_hi_rd == 16'hFFFF, "R1 hi", {16'h0, mask_hi_rd}, 32'hFFFF);
    rst_n = 1'b1;

    // R1: first frame without sync pulse runs with everything enabled
    for (int i = 0; i < 3; i++) do_slot(i, 24'h100 + 24'(i), 1'b1);
    chk(slot_idx == 5'd3, "R4 step", {27'h0, slot_idx}, 32'h3);

    // R3: mid-frame write does not alter this frame
    frame();
    do_slot(0, 24'hA00000, 1'b1);
    write_mask(1'b0, 16'h0005);
    for (int i = 1; i < 4; i++) do_slot(i, 24'hA00000 + 24'(i), 1'b1);

    // R3, R6: next frame uses the new mask (slots 0 and 2 only)
    frame();
    for (int i = 0; i < 4; i++) do_slot(i, 24'hB00000 + 24'(i), 1'b1);
    chk(rxd_valid == 1'b0, "R7 drained", {31'h0, rxd_valid}, 32'h0);

    // R2, R4: high half gates slots 16-31; slot 31 and saturated slots enabled
    write_mask(1'b0, 16'h0000);
    write_mask(1'b1, 16'h8001);
    frame();
    for (int i = 0; i < 34; i++) do_slot(i, 24'hC00000 + 24'(i), 1'b1);
    chk(slot_idx == 5'd31, "R4 saturate", {27'h0, slot_idx}, 32'd31);

    // R6: bit 0 clear in normal use receives nothing
    write_mask(1'b1, 16'h0000);
    write_mask(1'b0, 16'hFFFE);
    frame();
    do_slot(0, 24'hD00000, 1'b1);
    chk(rxd_valid == 1'b0, "R6 slot0 masked", {31'h0, rxd_valid}, 32'h0);

    // R8: overrun with a disabled slot between
    write_mask(1'b0, 16'hFFFD);
    frame();
    mon_en = 1'b0;
    do_slot(0, 24'hE00000, 1'b0);
    do_slot(1, 24'hE00001, 1'b0);
    chk(rxd_data == 24'hE00000, "R6 data kept", {8'h0, rxd_data}, 32'hE00000);
    chk(overrun == 1'b0, "R6 no overrun", {31'h0, overrun}, 32'h0);
    chk(rxd_valid == 1'b1, "R6 valid kept", {31'h0, rxd_valid}, 32'h1);
    do_slot(2, 24'hE00002, 1'b1);
    chk(overrun == 1'b1, "R8 overrun set", {31'h0, overrun}, 32'h1);
    @(negedge clk);
    overrun_clr = 1'b1;
    @(negedge clk);
    overrun_clr = 1'b0;
    chk(overrun == 1'b0, "R8 overrun clear", {31'h0, overrun}, 32'h0);
    mon_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(rxd_valid == 1'b0, "R7 read clears", {31'h0, rxd_valid}, 32'h0);
    chk(sbq.size() == 0, "R5 scoreboard empty", sbq.size(), 32'h0);
    finish_run();
  end
endmodule